// File: doc/BRIEF.md
# Virtual Screen Geometry Unit

This block keeps the geometry of a virtual frame that is larger than the visible screen. Software writes a requested virtual width. The block works out how many bytes one line takes at the current pixel depth. It then divides the video memory size by that line length to get the virtual height. If the requested width cannot hold the visible screen, the block rejects it and leaves every output as it was.

When an X or Y panning offset is written, the block works out the byte address of the first displayed pixel. It presents that address in 32-bit word units.

The current horizontal resolution, vertical resolution and bits per pixel come in as plain inputs from the neighbouring mode logic. Writes arrive as a one-cycle strobe with a two-bit select and a data value. The division runs as a sequential restoring divider that produces one quotient bit per cycle. A busy output stays high while it runs.

Top module: `vscreen_geom`

## Requirements
- R1: After reset, `busy`, `line_offset`, `virt_width`, `virt_height` and `start_addr` are all zero.
- R2: A width write (select 0) whose value is below `cur_xres` is rejected. `busy` stays low and no output changes.
- R3: Line bytes are width >> 1 when `cur_bpp` is 4. For any other depth they are width × ((bpp + 7) >> 3).
- R4: The virtual height is MEM_SIZE divided by the line bytes, using integer division.
- R5: A width write is rejected, and no output changes, when the computed virtual height is below the `cur_yres` sampled with the write.
- R6: An accepted width write updates `virt_width`, `virt_height` and `line_offset` on the same clock edge. That edge is the one on which `busy` falls.
- R7: `busy` rises on the edge that accepts a width write. With the default MEM_SIZE of 2^20 it stays high for exactly 22 cycles. Any write that arrives while `busy` is high is ignored.
- R8: An X offset write (select 1) or a Y offset write (select 2) sets `start_addr` on the next edge. The value is (line_offset × Y + Xb) >> 2, where Xb is X >> 1 at 4 bpp and X × ((bpp + 7) >> 3) otherwise. The other offset keeps its last written value.
- R9: A width write whose line bytes come out as zero is rejected without starting a division. This covers a depth of 0, or a width of 0 or 1 at 4 bpp.
- R10: A write with select 3 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 2 | 0 virtual width, 1 X offset, 2 Y offset, 3 unused |
| wr_data | input | VAL_W | Write value |
| cur_xres | input | VAL_W | Current visible width in pixels |
| cur_yres | input | VAL_W | Current visible height in lines |
| cur_bpp | input | BPP_W | Current bits per pixel |
| busy | output | 1 | Division in progress |
| line_offset | output | LB_W | Bytes per virtual line |
| virt_width | output | VAL_W | Accepted virtual width in pixels |
| virt_height | output | QW | Virtual height in lines |
| start_addr | output | SA_W | Display start address in 32-bit words |

## Verification
A divider that drops or shifts a quotient bit shows up as a wrong `virt_height` on the very edge where `busy` falls. It can also show up as a width that should have been accepted being rejected, or the reverse. A stale pending line length or a stale panning register stays hidden until the next offset write. It then appears one cycle later as a wrong `start_addr`. For that reason, every width case in the sweep is followed by offset writes that use the newly committed line length. A busy flag that falls too early or too late shows up directly as a wrong cycle count.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic [1:0] {
        SEL_VWIDTH = 2'd0,
        SEL_XOFF   = 2'd1,
        SEL_YOFF   = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_DONE = 2'd2
    } dstate_e;

endpackage

// File: rtl/vsg_bytes.sv
module vsg_bytes #(
    parameter int VAL_W = 16,
    parameter int BPP_W = 6,
    parameter int OUT_W = VAL_W + BPP_W - 2
) (
    input  logic [VAL_W-1:0] pixels,
    input  logic [BPP_W-1:0] bpp,
    output logic [OUT_W-1:0] bytes
);
    logic [BPP_W:0] factor;

    always_comb begin
        factor = ({1'b0, bpp} + (BPP_W+1)'(7)) >> 3;
        if (bpp == BPP_W'(4)) begin
            bytes = OUT_W'(pixels >> 1);
        end else begin
            bytes = OUT_W'(OUT_W'(pixels) * OUT_W'(factor));
        end
    end

endmodule

// File: rtl/vsg_div.sv
module vsg_div
    import vsg_pkg::*;
#(
    parameter int NUM_W = 21,
    parameter int DEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W + 1);

    typedef struct packed {
        dstate_e          st;
        logic [CW-1:0]    cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] wq;
        logic [DEN_W-1:0] dv;
    } dv_t;

    dv_t q, d;
    logic [DEN_W:0] shifted;
    logic [DEN_W:0] diff;
    logic           fits;

    always_comb begin
        d       = q;
        shifted = {q.rem, q.wq[NUM_W-1]};
        fits    = shifted >= {1'b0, q.dv};
        diff    = shifted - {1'b0, q.dv};
        case (q.st)
            DV_IDLE: begin
                if (start) begin
                    d.st  = DV_RUN;
                    d.cnt = CW'(NUM_W);
                    d.rem = '0;
                    d.wq  = num;
                    d.dv  = den;
                end
            end
            DV_RUN: begin
                d.rem = fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                d.wq  = {q.wq[NUM_W-2:0], fits};
                d.cnt = q.cnt - CW'(1);
                if (q.cnt == CW'(1)) d.st = DV_DONE;
            end
            default: d.st = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: DV_IDLE, cnt: '0, rem: '0, wq: '0, dv: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != DV_IDLE);
    assign done = (q.st == DV_DONE);
    assign quo  = q.wq;

    // The partial remainder never reaches the divisor during a restoring run (R4)
    p_rem_below_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == DV_RUN) |-> (q.rem < q.dv));

    // A run never begins with a zero divisor (R9)
    p_no_zero_den_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == DV_RUN) |-> (q.dv != '0));

endmodule

// File: rtl/vscreen_geom.sv
module vscreen_geom
    import vsg_pkg::*;
#(
    parameter int VAL_W    = 16,
    parameter int BPP_W    = 6,
    parameter int MEM_SIZE = 1 << 20,
    localparam int LB_W    = VAL_W + BPP_W - 2,
    localparam int QW      = $clog2(MEM_SIZE + 1),
    localparam int SB_W    = LB_W + VAL_W + 1,
    localparam int SA_W    = SB_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    input  logic [VAL_W-1:0] cur_xres,
    input  logic [VAL_W-1:0] cur_yres,
    input  logic [BPP_W-1:0] cur_bpp,
    output logic             busy,
    output logic [LB_W-1:0]  line_offset,
    output logic [VAL_W-1:0] virt_width,
    output logic [QW-1:0]    virt_height,
    output logic [SA_W-1:0]  start_addr
);
    localparam int CMP_W = (QW > VAL_W) ? QW : VAL_W;

    typedef struct packed {
        logic [LB_W-1:0]  lo;
        logic [VAL_W-1:0] vw;
        logic [QW-1:0]    vh;
        logic [VAL_W-1:0] xo;
        logic [VAL_W-1:0] yo;
        logic [SA_W-1:0]  sa;
        logic [VAL_W-1:0] pend_w;
        logic [LB_W-1:0]  pend_lb;
        logic [VAL_W-1:0] pend_yres;
    } geo_t;

    geo_t q, d;

    logic             div_busy, div_done, div_start;
    logic [QW-1:0]    div_quo;
    logic [LB_W-1:0]  lb_new;
    logic [LB_W-1:0]  xb_new;
    logic [VAL_W-1:0] x_use, y_use;
    logic [SB_W-1:0]  sb_new;
    sel_e             sel;

    assign sel = sel_e'(wr_sel);

    vsg_bytes #(.VAL_W(VAL_W), .BPP_W(BPP_W), .OUT_W(LB_W)) u_line_bytes (
        .pixels (wr_data),
        .bpp    (cur_bpp),
        .bytes  (lb_new)
    );

    vsg_bytes #(.VAL_W(VAL_W), .BPP_W(BPP_W), .OUT_W(LB_W)) u_x_bytes (
        .pixels (x_use),
        .bpp    (cur_bpp),
        .bytes  (xb_new)
    );

    vsg_div #(.NUM_W(QW), .DEN_W(LB_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (QW'(MEM_SIZE)),
        .den   (lb_new),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_comb begin
        d         = q;
        div_start = 1'b0;
        x_use     = (wr_en && sel == SEL_XOFF) ? wr_data : q.xo;
        y_use     = (wr_en && sel == SEL_YOFF) ? wr_data : q.yo;
        sb_new    = SB_W'(q.lo) * SB_W'(y_use) + SB_W'(xb_new);

        if (wr_en && !div_busy) begin
            case (sel)
                SEL_VWIDTH: begin
                    if (wr_data >= cur_xres && lb_new != '0) begin
                        d.pend_w    = wr_data;
                        d.pend_lb   = lb_new;
                        d.pend_yres = cur_yres;
                        div_start   = 1'b1;
                    end
                end
                SEL_XOFF, SEL_YOFF: begin
                    d.xo = x_use;
                    d.yo = y_use;
                    d.sa = sb_new[SB_W-1:2];
                end
                default: ;
            endcase
        end

        if (div_done && (CMP_W'(div_quo) >= CMP_W'(q.pend_yres))) begin
            d.vw = q.pend_w;
            d.vh = div_quo;
            d.lo = q.pend_lb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy        = div_busy;
    assign line_offset = q.lo;
    assign virt_width  = q.vw;
    assign virt_height = q.vh;
    assign start_addr  = q.sa;

    // A width narrower than the screen starts nothing and changes nothing (R2)
    p_narrow_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && sel == SEL_VWIDTH && wr_data < cur_xres)
        |=> (!busy && $stable(virt_width) && $stable(line_offset) && $stable(virt_height)));

    // Geometry outputs change only on the edge where busy falls (R6)
    p_commit_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(virt_width) || !$stable(line_offset) || !$stable(virt_height)) |-> $fell(busy));

    // Offset writes are ignored while busy, so the start address holds (R7)
    p_busy_holds_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(start_addr));

    // A pending division always carries a nonzero line length (R9)
    p_pend_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.pend_lb != '0));

    // The unused select leaves every output alone (R10)
    p_unused_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && sel == SEL_NONE)
        |=> ($stable(start_addr) && $stable(virt_width) && !busy));

endmodule

// File: tb/tb_vscreen_geom.sv
module tb_vscreen_geom;
    localparam int VAL_W = 16;
    localparam int BPP_W = 6;
    localparam longint MEM = 1 << 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [VAL_W-1:0] wr_data = '0;
    logic [VAL_W-1:0] cur_xres = 16'd640;
    logic [VAL_W-1:0] cur_yres = 16'd480;
    logic [BPP_W-1:0] cur_bpp = 6'd8;
    logic             busy;
    logic [19:0]      line_offset;
    logic [15:0]      virt_width;
    logic [20:0]      virt_height;
    logic [34:0]      start_addr;

    vscreen_geom dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_data (wr_data), .cur_xres (cur_xres), .cur_yres (cur_yres),
        .cur_bpp (cur_bpp), .busy (busy), .line_offset (line_offset),
        .virt_width (virt_width), .virt_height (virt_height),
        .start_addr (start_addr)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    longint m_lo = 0, m_vw = 0, m_vh = 0, m_sa = 0, m_xo = 0, m_yo = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint pix_bytes(input longint px, input longint bpp);
        if (bpp == 4) return px / 2;
        return px * ((bpp + 7) / 8);
    endfunction

    task automatic check_all(input string tag);
        check({tag, " line_offset"}, longint'(line_offset), m_lo);
        check({tag, " virt_width"},  longint'(virt_width),  m_vw);
        check({tag, " virt_height"}, longint'(virt_height), m_vh);
        check({tag, " start_addr"},  longint'(start_addr),  m_sa);
    endtask

    task automatic pulse(input logic [1:0] sel, input longint val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = VAL_W'(val);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_width(input longint w);
        longint lb, vh;
        int cyc;
        bit ok;
        lb  = pix_bytes(w, cur_bpp);
        vh  = (lb != 0) ? MEM / lb : 0;
        ok  = (w >= cur_xres) && (lb != 0) && (vh >= cur_yres);
        pulse(2'd0, w);
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
        if (w < cur_xres || lb == 0) begin
            check("R2/R9 busy cycles on early reject", cyc, 0);
        end else begin
            check("R7 busy cycle count", cyc, 22);
        end
        if (ok) begin
            m_lo = lb; m_vw = w; m_vh = vh;
        end
        check_all($sformatf("R3/R4/R5/R6 w=%0d bpp=%0d", w, cur_bpp));
    endtask

    task automatic set_off(input bit is_y, input longint v);
        if (is_y) m_yo = v; else m_xo = v;
        m_sa = (m_lo * m_yo + pix_bytes(m_xo, cur_bpp)) >> 2;
        pulse(is_y ? 2'd2 : 2'd1, v);
        check($sformatf("R8 start x=%0d y=%0d bpp=%0d", m_xo, m_yo, cur_bpp),
              longint'(start_addr), m_sa);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int bpps[7] = '{4, 8, 15, 16, 24, 32, 0};
        int wids[9] = '{1, 639, 640, 641, 800, 1024, 1600, 2048, 4096};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", longint'(busy), 0);
        check_all("R1 reset");

        // R9: zero line bytes when xres is zero and width is zero
        cur_xres = 0;
        set_width(0);
        cur_xres = 640;

        // R2/R3/R4/R5/R6/R8/R9 sweep of depth and width
        foreach (bpps[i]) begin
            cur_bpp = 6'(bpps[i]);
            foreach (wids[j]) begin
                set_width(wids[j]);
                set_off(1'b0, 13);
                set_off(1'b1, 7);
                set_off(1'b0, 0);
                set_off(1'b1, 0);
            end
        end

        // R5: small memory boundary, height exactly equal to yres then one above
        cur_bpp  = 6'd32;
        cur_xres = 16'd64;
        cur_yres = 16'd1024;
        set_width(256);   // lb 1024, vh 1024 == yres, accepted
        cur_yres = 16'd1025;
        set_width(128);   // vh 2048, accepted
        set_width(256);   // vh 1024 < 1025, rejected
        cur_yres = 16'd480;
        cur_xres = 16'd640;

        // R10: unused select
        cur_bpp = 6'd16;
        set_width(1024);
        set_off(1'b0, 100);
        pulse(2'd3, 16'hFFFF);
        check("R10 busy after unused select", longint'(busy), 0);
        check_all("R10 unused select");

        // R7: writes while busy are ignored
        pulse(2'd0, 800);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd999;
        @(negedge clk);
        wr_sel = 2'd0; wr_data = 16'd2048;
        @(negedge clk);
        wr_en = 1'b0;
        while (busy) @(negedge clk);
        m_lo = 1600; m_vw = 800; m_vh = MEM / 1600;
        check_all("R7 writes while busy ignored");
        set_off(1'b1, 3);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule